// File: doc/BRIEF.md
# Analog Switch Turn-On Sequencer

This block decides when five analog switch groups of a headset path close after a turn-on request: left audio, right audio, microphone, sense and audio ground. Left audio is the anchor. It closes in the cycle the request is taken. Every other group waits for its own programmable start offset, counted from that moment. When slow mode is on, each group then spends a programmable soft-start interval in a ramp phase. During that phase an external analog driver limits the switch slew.

Time is counted in base units. A base unit is one pulse of a single-cycle tick strobe that comes from outside. Each group turns its 8-bit code into a unit count with its own formula. The settings and the slow-mode choice are latched when the request rises. Dropping the request opens every switch and discards every pending timer.

Top module: `swon_seq`

## Requirements
- R1: Group order on `en_o`/`ramp_o` bits is 0 left, 1 right, 2 mic, 3 sense, 4 ground. Left enable rises at the clock edge that first samples `start_i` high (the launch edge). A group with delay code d enables at the edge that samples the (d*STEP)-th tick after the launch edge. d=0 enables at the launch edge.
- R2: With slow mode latched on, left, right and sense assert `ramp_o` together with their enable. `ramp_o` falls (code+1)*STEP ticks later.
- R3: The mic ramp lasts code*STEP+MIC_OFS ticks. Code 0 is treated as code 1.
- R4: The ground ramp lasts (code+1)*GND_STEP ticks.
- R5: With slow mode latched off, no group ever asserts `ramp_o`. Each enable still rises at its R1 time.
- R6: An edge that samples `start_i` low clears all `en_o` and `ramp_o` bits. Pending timers are discarded, and a later request starts a fresh sequence.
- R7: Timers advance only at edges that sample `tick_i` high. A tick sampled at the launch edge is not counted. Without ticks the outputs hold.
- R8: Codes and `slow_en_i` are captured at the launch edge. Changes made while the request is held have no effect.
- R9: While `rst` is high, and after its release, every output is 0.
- R10: While the request is held, an enable never falls, and `ramp_o` of a group is only high while its `en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Turn-on request, level |
| tick_i | input | 1 | Base time unit strobe, one cycle |
| slow_en_i | input | 1 | Slow turn-on mode |
| ramp_code_l_i | input | CODE_W | Left ramp code |
| ramp_code_r_i | input | CODE_W | Right ramp code |
| ramp_code_mic_i | input | CODE_W | Mic ramp code |
| ramp_code_sns_i | input | CODE_W | Sense ramp code |
| ramp_code_gnd_i | input | CODE_W | Ground ramp code |
| dly_code_r_i | input | CODE_W | Right start offset code |
| dly_code_mic_i | input | CODE_W | Mic start offset code |
| dly_code_sns_i | input | CODE_W | Sense start offset code |
| dly_code_gnd_i | input | CODE_W | Ground start offset code |
| en_o | output | 5 | Per-group switch enable |
| ramp_o | output | 5 | Per-group ramp phase active |

## Verification
The hardest case to reach is a request dropped while some groups are still in their start offset and others are mid-ramp. The timers must then be discarded and must not carry into the next request. The stimulus uses staggered offsets with an irregular tick pattern and drops the request partway through. It then replays a full sequence and checks that every event time counts from the new launch edge. Settings are also rewritten to extreme values right after launch, and ticks are paused mid-ramp, to show that the latched values and the tick gating rule the timing.

// File: rtl/swon_pkg.sv
package swon_pkg;
  localparam int NG = 5;

  typedef enum logic [1:0] {K_LEFT, K_STD, K_MIC, K_GND} grp_kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_RAMP, PH_ON} phase_e;

  function automatic grp_kind_e kind_of(input int g);
    case (g)
      0:       return K_LEFT;
      2:       return K_MIC;
      4:       return K_GND;
      default: return K_STD;
    endcase
  endfunction
endpackage

// File: rtl/swon_time_map.sv
module swon_time_map #(
  parameter swon_pkg::grp_kind_e KIND = swon_pkg::K_STD,
  parameter int CODE_W   = 8,
  parameter int CNT_W    = 18,
  parameter int STEP     = 100,
  parameter int MIC_OFS  = 150,
  parameter int GND_STEP = 700
) (
  input  logic [CODE_W-1:0] ramp_code_i,
  input  logic [CODE_W-1:0] dly_code_i,
  output logic [CNT_W-1:0]  ramp_ticks_o,
  output logic [CNT_W-1:0]  dly_ticks_o
);
  localparam logic [CNT_W-1:0] K_STEP = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] K_OFS  = CNT_W'(MIC_OFS);
  localparam logic [CNT_W-1:0] K_GSTP = CNT_W'(GND_STEP);

  logic [CNT_W-1:0] code_w;
  assign code_w = CNT_W'(ramp_code_i);

  generate
    if (KIND == swon_pkg::K_LEFT) begin : g_left
      assign dly_ticks_o  = '0;
      assign ramp_ticks_o = (code_w + CNT_W'(1)) * K_STEP;
    end else if (KIND == swon_pkg::K_MIC) begin : g_mic
      logic [CNT_W-1:0] eff;
      assign eff          = (code_w == '0) ? CNT_W'(1) : code_w;
      assign dly_ticks_o  = CNT_W'(dly_code_i) * K_STEP;
      assign ramp_ticks_o = eff * K_STEP + K_OFS;
    end else if (KIND == swon_pkg::K_GND) begin : g_gnd
      assign dly_ticks_o  = CNT_W'(dly_code_i) * K_STEP;
      assign ramp_ticks_o = (code_w + CNT_W'(1)) * K_GSTP;
    end else begin : g_std
      assign dly_ticks_o  = CNT_W'(dly_code_i) * K_STEP;
      assign ramp_ticks_o = (code_w + CNT_W'(1)) * K_STEP;
    end
  endgenerate
endmodule

// File: rtl/swon_group_timer.sv
module swon_group_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             launch_i,
  input  logic             tick_i,
  input  logic             slow_en_i,
  input  logic [CNT_W-1:0] dly_ticks_i,
  input  logic [CNT_W-1:0] ramp_ticks_i,
  output logic             en_o,
  output logic             ramp_o
);
  import swon_pkg::*;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rt_q;
  logic             slow_q;
  logic             en_q;
  logic             ramp_q;

  always_ff @(posedge clk) begin
    if (rst || !start_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rt_q    <= '0;
      slow_q  <= 1'b0;
      en_q    <= 1'b0;
      ramp_q  <= 1'b0;
    end else if (launch_i) begin
      rt_q   <= ramp_ticks_i;
      slow_q <= slow_en_i;
      if (dly_ticks_i == '0) begin
        en_q <= 1'b1;
        if (slow_en_i) begin
          phase_q <= PH_RAMP;
          ramp_q  <= 1'b1;
          cnt_q   <= ramp_ticks_i;
        end else begin
          phase_q <= PH_ON;
        end
      end else begin
        phase_q <= PH_WAIT;
        cnt_q   <= dly_ticks_i;
      end
    end else if (tick_i) begin
      case (phase_q)
        PH_WAIT: begin
          if (cnt_q == CNT_W'(1)) begin
            en_q <= 1'b1;
            if (slow_q) begin
              phase_q <= PH_RAMP;
              ramp_q  <= 1'b1;
              cnt_q   <= rt_q;
            end else begin
              phase_q <= PH_ON;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_RAMP: begin
          if (cnt_q == CNT_W'(1)) begin
            ramp_q  <= 1'b0;
            phase_q <= PH_ON;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign en_o   = en_q;
  assign ramp_o = ramp_q;
endmodule

// File: rtl/swon_seq.sv
module swon_seq #(
  parameter int CODE_W   = 8,
  parameter int STEP     = 100,
  parameter int MIC_OFS  = 150,
  parameter int GND_STEP = 700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              slow_en_i,
  input  logic [CODE_W-1:0] ramp_code_l_i,
  input  logic [CODE_W-1:0] ramp_code_r_i,
  input  logic [CODE_W-1:0] ramp_code_mic_i,
  input  logic [CODE_W-1:0] ramp_code_sns_i,
  input  logic [CODE_W-1:0] ramp_code_gnd_i,
  input  logic [CODE_W-1:0] dly_code_r_i,
  input  logic [CODE_W-1:0] dly_code_mic_i,
  input  logic [CODE_W-1:0] dly_code_sns_i,
  input  logic [CODE_W-1:0] dly_code_gnd_i,
  output logic [4:0]        en_o,
  output logic [4:0]        ramp_o
);
  import swon_pkg::*;

  localparam int MAXSTEP = (GND_STEP > STEP) ? GND_STEP : STEP;
  localparam int CNT_W   = $clog2((2**CODE_W) * MAXSTEP + MIC_OFS + 1);

  logic              armed_q;
  logic              launch;
  logic [CODE_W-1:0] rc [NG];
  logic [CODE_W-1:0] dc [NG];

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= start_i;
  end
  assign launch = start_i & ~armed_q;

  assign rc[0] = ramp_code_l_i;
  assign rc[1] = ramp_code_r_i;
  assign rc[2] = ramp_code_mic_i;
  assign rc[3] = ramp_code_sns_i;
  assign rc[4] = ramp_code_gnd_i;
  assign dc[0] = '0;
  assign dc[1] = dly_code_r_i;
  assign dc[2] = dly_code_mic_i;
  assign dc[3] = dly_code_sns_i;
  assign dc[4] = dly_code_gnd_i;

  generate
    for (genvar g = 0; g < NG; g++) begin : g_grp
      logic [CNT_W-1:0] ramp_ticks;
      logic [CNT_W-1:0] dly_ticks;

      swon_time_map #(
        .KIND(kind_of(g)), .CODE_W(CODE_W), .CNT_W(CNT_W),
        .STEP(STEP), .MIC_OFS(MIC_OFS), .GND_STEP(GND_STEP)
      ) u_map (
        .ramp_code_i (rc[g]),
        .dly_code_i  (dc[g]),
        .ramp_ticks_o(ramp_ticks),
        .dly_ticks_o (dly_ticks)
      );

      swon_group_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .launch_i    (launch),
        .tick_i      (tick_i),
        .slow_en_i   (slow_en_i),
        .dly_ticks_i (dly_ticks),
        .ramp_ticks_i(ramp_ticks),
        .en_o        (en_o[g]),
        .ramp_o      (ramp_o[g])
      );
    end
  endgenerate
endmodule

// File: rtl/swon_seq_chk.sv
module swon_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       tick_i,
  input logic       slow_en_i,
  input logic [4:0] en_o,
  input logic [4:0] ramp_o
);
  // R9: reset forces every output low
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (en_o == '0 && ramp_o == '0));

  // R6: a sampled low request clears everything
  a_r6_drop_clears: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (en_o == '0 && ramp_o == '0));

  // R1: left closes at the launch edge
  a_r1_left_at_launch: assert property (@(posedge clk) disable iff (rst)
    (start_i && !$past(start_i) && !$past(rst)) |=> en_o[0]);

  // R5: no ramp right after a launch in fast mode
  a_r5_fast_no_ramp: assert property (@(posedge clk) disable iff (rst)
    (start_i && !$past(start_i) && !$past(rst) && !slow_en_i) |=> (ramp_o == '0));

  // R7: without a tick and without a launch the outputs hold
  a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (start_i && $past(start_i) && !$past(rst) && !tick_i) |=> ($stable(en_o) && $stable(ramp_o)));

  // R10: enables never fall while the request is held
  a_r10_en_sticky: assert property (@(posedge clk) disable iff (rst)
    start_i |=> ((en_o & $past(en_o)) == $past(en_o)) || !start_i);

  // R10: ramp only with enable
  a_r10_ramp_needs_en: assert property (@(posedge clk) disable iff (rst)
    (ramp_o & ~en_o) == '0);
endmodule

bind swon_seq swon_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
  .slow_en_i(slow_en_i), .en_o(en_o), .ramp_o(ramp_o)
);

// File: tb/sim_swon_seq.sv
module sim_swon_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       slow_en_i = 1'b0;
  logic [7:0] rc_l = 8'h01, rc_r = 8'h01, rc_m = 8'h01, rc_s = 8'h01, rc_g = 8'h01;
  logic [7:0] dc_r = 8'h00, dc_m = 8'h00, dc_s = 8'h00, dc_g = 8'h00;
  logic [4:0] en_o, ramp_o;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  tick_gate = 1'b1;
  bit  finished = 1'b0;

  typedef struct {int key; int grp; int kind; int t; string req;} ev_t;
  ev_t exq[$];

  always #10 clk = ~clk;

  swon_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i), .slow_en_i(slow_en_i),
    .ramp_code_l_i(rc_l), .ramp_code_r_i(rc_r), .ramp_code_mic_i(rc_m),
    .ramp_code_sns_i(rc_s), .ramp_code_gnd_i(rc_g),
    .dly_code_r_i(dc_r), .dly_code_mic_i(dc_m), .dly_code_sns_i(dc_s),
    .dly_code_gnd_i(dc_g), .en_o(en_o), .ramp_o(ramp_o)
  );

  // irregular tick pattern: two of every three cycles
  always @(negedge clk) begin
    cyc++;
    tick_i <= tick_gate && (cyc % 3 != 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int g, input int k, input int t, input string req);
    ev_t e;
    int  i;
    e.key = t * 16 + g * 3 + k; e.grp = g; e.kind = k; e.t = t; e.req = req;
    i = 0;
    while (i < exq.size() && exq[i].key <= e.key) i++;
    exq.insert(i, e);
  endtask

  // monitor: tick count since launch, pop and compare each output change
  initial begin
    int   tcnt = 0;
    bit   pstart = 1'b0;
    logic [4:0] pen = '0, pramp = '0;
    forever begin
      @(posedge clk); #2;
      if (rst) begin
        pstart = 1'b0; pen = '0; pramp = '0;
      end else if (!start_i) begin
        if (en_o != '0 || ramp_o != '0)
          check(1'b0, "R6 idle outputs", {en_o, ramp_o}, 0);
        pstart = 1'b0; pen = '0; pramp = '0;
      end else begin
        if (!pstart) tcnt = 0;
        else if (tick_i) tcnt++;
        for (int g = 0; g < 5; g++) begin
          for (int k = 0; k < 3; k++) begin
            bit hit;
            hit = (k == 0) ? (en_o[g] && !pen[g]) :
                  (k == 1) ? (ramp_o[g] && !pramp[g]) : (!ramp_o[g] && pramp[g]);
            if (hit) begin
              if (exq.size() == 0) begin
                check(1'b0, "R1 unexpected event", g * 10 + k, -1);
              end else begin
                ev_t e;
                e = exq.pop_front();
                check(e.grp == g && e.kind == k && e.t == tcnt, e.req,
                      g * 100000 + k * 10000 + tcnt, e.grp * 100000 + e.kind * 10000 + e.t);
              end
            end
          end
          if (pen[g] && !en_o[g]) check(1'b0, "R10 enable fell", g, 1);
        end
        pen = en_o; pramp = ramp_o; pstart = 1'b1;
      end
    end
  end

  function automatic int ramp_len(input int g, input int c);
    if (g == 2) return ((c == 0) ? 1 : c) * 100 + 150;
    if (g == 4) return (c + 1) * 700;
    return (c + 1) * 100;
  endfunction

  function automatic string ramp_req(input int g);
    if (g == 2) return "R3 mic ramp end";
    if (g == 4) return "R4 ground ramp end";
    return "R2 ramp end";
  endfunction

  // driver: program codes, push expectations, run one request
  task automatic run_seq(input bit slow, input int rc [5], input int dc [5],
                         input bit perturb, input bit pause, input int abort_n);
    int maxt = 0;
    @(negedge clk);
    rc_l = 8'(rc[0]); rc_r = 8'(rc[1]); rc_m = 8'(rc[2]); rc_s = 8'(rc[3]); rc_g = 8'(rc[4]);
    dc_r = 8'(dc[1]); dc_m = 8'(dc[2]); dc_s = 8'(dc[3]); dc_g = 8'(dc[4]);
    slow_en_i = slow;
    for (int g = 0; g < 5; g++) begin
      int d;
      d = (g == 0) ? 0 : dc[g] * 100;
      expect_ev(g, 0, d, slow ? "R1 enable time" : "R5 enable time, fast");
      if (slow) begin
        expect_ev(g, 1, d, "R2 ramp start");
        expect_ev(g, 2, d + ramp_len(g, rc[g]), ramp_req(g));
        if (d + ramp_len(g, rc[g]) > maxt) maxt = d + ramp_len(g, rc[g]);
      end else if (d > maxt) maxt = d;
    end
    start_i = 1'b1;
    if (perturb) begin
      repeat (5) @(negedge clk);
      rc_l = 8'hFF; rc_r = 8'hFF; rc_m = 8'hFF; rc_s = 8'hFF; rc_g = 8'hFF;
      dc_r = 8'hFF; dc_m = 8'hFF; dc_s = 8'hFF; dc_g = 8'hFF;
      slow_en_i = ~slow;
    end
    if (pause) begin
      logic [9:0] snap;
      repeat (90) @(negedge clk);
      @(posedge clk); #5 tick_gate = 1'b0;
      @(negedge clk); @(negedge clk);
      snap = {en_o, ramp_o};
      repeat (60) @(negedge clk);
      check({en_o, ramp_o} == snap, "R7 hold without ticks", {en_o, ramp_o}, snap);
      @(posedge clk); #5 tick_gate = 1'b1;
    end
    if (abort_n > 0) begin
      repeat (abort_n) @(negedge clk);
      start_i = 1'b0;
      exq.delete();
      @(negedge clk);
      check(en_o == '0 && ramp_o == '0, "R6 clear after drop", {en_o, ramp_o}, 0);
      repeat (50) @(negedge clk);
      check(en_o == '0 && ramp_o == '0, "R6 timers discarded", {en_o, ramp_o}, 0);
    end else begin
      repeat (maxt * 3 / 2 + 30) @(negedge clk);
      check(exq.size() == 0, perturb ? "R8 late changes ignored" : "R1 all events seen",
            exq.size(), 0);
      check(en_o == 5'h1F, "R10 all enabled at end", en_o, 5'h1F);
      check(ramp_o == '0, slow ? "R2 ramps finished" : "R5 no ramp", ramp_o, 0);
      start_i = 1'b0;
      exq.delete();
      @(negedge clk);
      check(en_o == '0 && ramp_o == '0, "R6 clear on drop", {en_o, ramp_o}, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(en_o == '0 && ramp_o == '0, "R9 outputs in reset", {en_o, ramp_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(en_o == '0 && ramp_o == '0, "R9 outputs after reset", {en_o, ramp_o}, 0);

    // staggered slow sequence, mic code 0 treated as 1, settings rewritten after launch
    run_seq(1'b1, '{0, 1, 0, 2, 0}, '{0, 1, 2, 0, 3}, 1'b1, 1'b0, 0);
    // fast mode, no ramps
    run_seq(1'b0, '{3, 3, 3, 3, 3}, '{0, 2, 1, 4, 0}, 1'b0, 1'b0, 0);
    // simultaneous start, longer mic and ground codes, ticks paused mid-ramp
    run_seq(1'b1, '{1, 0, 3, 0, 1}, '{0, 0, 0, 0, 0}, 1'b0, 1'b1, 0);
    // request dropped while groups are waiting and ramping
    run_seq(1'b1, '{0, 1, 0, 2, 0}, '{0, 1, 2, 0, 3}, 1'b0, 1'b0, 300);
    // fresh sequence after the abort
    run_seq(1'b1, '{2, 0, 1, 1, 0}, '{0, 3, 1, 2, 1}, 1'b0, 1'b0, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule